// File: doc/BRIEF.md
# Symmetric 31-Tap Integer FIR Filter with Fixed Scaling

This block low-pass filters a stream of signed 16-bit integer audio samples with a 31-tap finite impulse response whose coefficients are fixed when the design is built. A producer writes one sample per strobe. The filter shifts the sample into a tap history, computes the weighted sum of the most recent 31 samples, divides that sum by 256 and presents the result as a signed 32-bit word. The word stays in an output register until the next result replaces it, so a slow reader such as a parallel I/O port can sample it whenever it likes.

The coefficient set is mirror-symmetric. Because of this, the block adds each pair of taps that share a weight before the multiply. Fifteen pair sums and the lone centre tap give 16 products instead of 31. The datapath is pipelined over three clock edges, so it accepts a new sample on every clock.

Coefficient k has the value 4*min(k, 30-k) - 16. This runs from -16 at the two ends up to 44 at the centre tap 15, and weight k multiplies the sample written k strobes before the newest one.

Top module: `fir31_sym`

## Requirements
- R1: While `rst` is high at a rising edge, the block clears the tap history, `out_sample` and `out_valid` to zero. The first result after reset therefore depends only on the first sample written.
- R2: A strobe on `in_valid` at a rising edge raises `out_valid` for exactly one cycle after the third rising edge, counting the capturing edge as the first. Each strobe produces one pulse, and strobes on consecutive cycles produce consecutive pulses.
- R3: Each result equals floor(sum over k = 0..30 of c[k] * x[n-k] / 256), where x[n] is the newest sample. The shift by 8 is arithmetic, so it rounds toward minus infinity. The result is sign-extended to 32 bits.
- R4: The tap history advances only on a cycle where `in_valid` is high. Idle cycles between strobes leave it unchanged, so results after a gap match a stream written with no gap.
- R5: After reset, writing 256 followed by 30 zeros produces the results c[0], c[1], ..., c[30] in that order, one per strobe. The output is never their sum.
- R6: The coefficients satisfy c[k] = c[30-k], with c[k] = 4*min(k, 30-k) - 16.
- R7: The result is exact with no wrap-around for every combination of full-scale inputs (-32768 and +32767), including the largest positive and largest negative sums.
- R8: `out_sample` holds its value on every cycle on which `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Write strobe: capture `in_sample` at this edge |
| in_sample | input | 16 | Signed input sample |
| out_valid | output | 1 | One-cycle pulse marking a new result |
| out_sample | output | 32 | Signed filtered, scaled result, held between pulses |

## Verification
An impulse of height 256 written right after reset must replay the coefficient list one value per strobe. This shows a correct tap order and an empty history, and it separates a filter that returns the coefficients from one that returns their total. Long runs of full-scale samples, both all -32768 and signs matched to the coefficients, drive the sums to their extremes to expose truncation or wrap-around. Seeded random bursts, written back-to-back and separated by idle gaps, are checked against a bench model. These bursts confirm the pipeline timing under continuous input and show that idle cycles neither shift the history nor disturb the held output.

// File: rtl/fir31_pkg.sv
package fir31_pkg;

    parameter int NTAPS = 31;
    parameter int DW    = 16;
    parameter int CW    = 8;
    parameter int OW    = 32;
    parameter int SHIFT = 8;

    localparam int NHALF = NTAPS / 2;
    localparam int NPAIR = (NTAPS + 1) / 2;
    localparam int SW    = DW + 1;
    localparam int PW    = SW + CW;
    localparam int ACCW  = PW + $clog2(NPAIR);

    typedef logic signed [DW-1:0]   sample_t;
    typedef logic signed [SW-1:0]   pair_t;
    typedef logic signed [CW-1:0]   coef_t;
    typedef logic signed [PW-1:0]   prod_t;
    typedef logic signed [ACCW-1:0] acc_t;
    typedef logic signed [OW-1:0]   out_t;

    typedef struct packed {
        logic valid;
        out_t value;
    } result_t;

    // Weight of tap k: mirror-symmetric ramp, negative at the ends.
    function automatic coef_t coef_at(input int k);
        int m;
        m = (k < NTAPS - 1 - k) ? k : NTAPS - 1 - k;
        return coef_t'(4 * m - 16);
    endfunction

endpackage

// File: rtl/fir31_delay.sv
module fir31_delay
    import fir31_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    shift,
    input  sample_t din,
    output sample_t taps [NTAPS]
);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NTAPS; i++) taps[i] <= '0;
        end else if (shift) begin
            taps[0] <= din;
            for (int i = 1; i < NTAPS; i++) taps[i] <= taps[i-1];
        end
    end

    // R4: history frozen on idle cycles
    a_r4_idle_frozen: assert property (@(posedge clk) disable iff (rst)
        !shift |=> ($stable(taps[0]) && $stable(taps[NTAPS-1])));

    // R4: a strobe moves each sample one place along
    a_r4_shift_moves: assert property (@(posedge clk) disable iff (rst)
        shift |=> (taps[1] == $past(taps[0])));

endmodule

// File: rtl/fir31_preadd.sv
module fir31_preadd
    import fir31_pkg::*;
(
    input  sample_t taps  [NTAPS],
    output pair_t   pairs [NPAIR]
);

    genvar k;
    generate
        for (k = 0; k < NHALF; k++) begin : g_pair
            assign pairs[k] = pair_t'(taps[k]) + pair_t'(taps[NTAPS-1-k]);
        end
        if (NTAPS % 2 == 1) begin : g_centre
            assign pairs[NHALF] = pair_t'(taps[NHALF]);
        end
    endgenerate

endmodule

// File: rtl/fir31_mac.sv
module fir31_mac
    import fir31_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    in_valid,
    input  pair_t   pairs [NPAIR],
    output result_t result
);

    prod_t prod_q [NPAIR];
    logic  prod_valid;
    acc_t  acc_sum;

    genvar k;
    generate
        for (k = 0; k < NPAIR; k++) begin : g_mul
            localparam coef_t WEIGHT = coef_at(k);
            always_ff @(posedge clk) begin
                if (rst) prod_q[k] <= '0;
                else if (in_valid) prod_q[k] <= prod_t'(pairs[k]) * prod_t'(WEIGHT);
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prod_valid <= 1'b0;
        else     prod_valid <= in_valid;
    end

    always_comb begin
        acc_sum = '0;
        for (int i = 0; i < NPAIR; i++) acc_sum = acc_sum + acc_t'(prod_q[i]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            result <= '0;
        end else begin
            result.valid <= prod_valid;
            if (prod_valid) result.value <= out_t'(acc_sum >>> SHIFT);
        end
    end

endmodule

// File: rtl/fir31_sym.sv
module fir31_sym
    import fir31_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic signed [15:0]   in_sample,
    output logic                 out_valid,
    output logic signed [31:0]   out_sample
);

    sample_t taps  [NTAPS];
    pair_t   pairs [NPAIR];
    logic    hist_valid;
    result_t result;

    fir31_delay i_delay (
        .clk   (clk),
        .rst   (rst),
        .shift (in_valid),
        .din   (sample_t'(in_sample)),
        .taps  (taps)
    );

    always_ff @(posedge clk) begin
        if (rst) hist_valid <= 1'b0;
        else     hist_valid <= in_valid;
    end

    fir31_preadd i_preadd (
        .taps  (taps),
        .pairs (pairs)
    );

    fir31_mac i_mac (
        .clk      (clk),
        .rst      (rst),
        .in_valid (hist_valid),
        .pairs    (pairs),
        .result   (result)
    );

    assign out_valid  = result.valid;
    assign out_sample = 32'(result.value);

    // R1: reset clears the output port state
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (!out_valid && out_sample == '0));

    // R2: every strobe yields a pulse three edges later
    a_r2_strobe_answered: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> ##3 out_valid);

    // R2: no pulse without a strobe three edges earlier
    a_r2_no_spurious: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid, 3));

    // R8: output holds between result pulses
    a_r8_hold_output: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> $stable(out_sample));

endmodule

// File: tb/test_fir31_sym.sv
module test_fir31_sym;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               in_valid = 1'b0;
    logic signed [15:0] in_sample = '0;
    logic               out_valid;
    logic signed [31:0] out_sample;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    int     hist [31];
    int     stim [64];
    longint expv [64];
    longint got  [64];
    longint last_y = 0;

    always #10 clk = ~clk;

    fir31_sym i_fir31_sym (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_sample  (in_sample),
        .out_valid  (out_valid),
        .out_sample (out_sample)
    );

    function automatic int bc(input int k);
        int m;
        m = (k < 30 - k) ? k : 30 - k;
        return 4 * m - 16;
    endfunction

    function automatic longint model_push(input int x);
        longint s;
        for (int i = 30; i > 0; i--) hist[i] = hist[i-1];
        hist[0] = x;
        s = 0;
        for (int i = 0; i < 31; i++) s += longint'(bc(i)) * longint'(hist[i]);
        return s >>> 8;
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic summary;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
    endtask

    // Writes stim[0..n-1] on consecutive cycles and checks each result.
    task automatic run_burst(input int n, input string req);
        for (int i = 0; i < n + 3; i++) begin
            @(negedge clk);
            if (i >= 3) begin
                chk(out_valid == 1'b1, "R2 pulse", longint'(out_valid), 1);
                chk(longint'(out_sample) == expv[i-3], req, longint'(out_sample), expv[i-3]);
                got[i-3] = longint'(out_sample);
            end else begin
                chk(out_valid == 1'b0, "R2 latency", longint'(out_valid), 0);
            end
            if (i < n) begin
                in_valid  = 1'b1;
                in_sample = 16'(stim[i]);
                expv[i]   = model_push(stim[i]);
            end else begin
                in_valid  = 1'b0;
            end
        end
        last_y = expv[n-1];
    endtask

    // Idle cycles: no pulse, output held (R8), history untouched (R4).
    task automatic idle(input int cycles);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            chk(out_valid == 1'b0, "R4 idle no pulse", longint'(out_valid), 0);
            chk(longint'(out_sample) == last_y, "R8 hold", longint'(out_sample), last_y);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20150701));
        for (int i = 0; i < 31; i++) hist[i] = 0;
        repeat (4) @(negedge clk);
        chk(out_valid == 1'b0, "R1 reset valid", longint'(out_valid), 0);
        chk(out_sample == 32'sd0, "R1 reset output", longint'(out_sample), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(out_sample == 32'sd0, "R1 after reset", longint'(out_sample), 0);

        // R5 impulse of 256 right after reset; first result also shows R1
        stim[0] = 256;
        for (int i = 1; i < 31; i++) stim[i] = 0;
        run_burst(31, "R3 impulse");
        chk(got[0] == -16, "R1 cleared history", got[0], -16);
        for (int k = 0; k < 31; k++)
            chk(got[k] == longint'(bc(k)), "R5 coefficient replay", got[k], longint'(bc(k)));
        for (int k = 0; k < 15; k++)
            chk(got[k] == got[30-k], "R6 symmetry", got[k], got[30-k]);
        idle(5);

        // R3/R4 random bursts separated by idle gaps
        for (int b = 0; b < 6; b++) begin
            int n;
            n = 5 + int'($urandom_range(35));
            for (int i = 0; i < n; i++) stim[i] = int'($urandom_range(65535)) - 32768;
            run_burst(n, "R3 random");
            idle(1 + int'($urandom_range(6)));
        end

        // R3 small-valued directed pattern: negative results round toward minus infinity
        for (int i = 0; i < 31; i++) stim[i] = (i % 3 == 0) ? -1 : 1;
        run_burst(31, "R3 rounding");
        idle(3);

        // R7 full scale: all most-negative
        for (int i = 0; i < 31; i++) stim[i] = -32768;
        run_burst(31, "R7 all negative");
        idle(2);
        // R7 signs matched to weights: largest positive sum
        for (int i = 0; i < 31; i++) stim[i] = (bc(30 - i) >= 0) ? 32767 : -32768;
        run_burst(31, "R7 max positive");
        idle(2);
        // R7 signs opposed: largest negative sum
        for (int i = 0; i < 31; i++) stim[i] = (bc(30 - i) >= 0) ? -32768 : 32767;
        run_burst(31, "R7 max negative");
        idle(4);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule